// File: doc/BRIEF.md
# Call-Depth Gated Reconvergence Training Table

This block holds a small, fully associative table of training entries. Each entry belongs to one static branch, identified by its PC. Every committed instruction is presented to all entries at once. The block decides which entries may learn from that instruction and reports the result as one enable bit per entry. The learning logic itself lives elsewhere and consumes this enable vector.

The block keeps a running call depth that follows committed calls and returns. When a branch commits, the block looks up its entry, or claims a new entry in round-robin order on a miss. It records the current depth as that entry's home level. An entry learns only when the committing instruction runs at its home level. It pauses while a deeper callee runs. When the function that owns it returns, the entry is retired. A separate query port reports whether a given branch PC has an entry, and which one.

Top module: `rcv_gate_table`

## Requirements
- R1: After reset, the call depth is 0, no entry holds a branch, the enable vector is all zero and every query misses.
- R2: An entry that has never been claimed by a committed branch never raises its enable bit.
- R3: A committed branch (kind 3) makes its entry active from the next committed instruction onward. The entry is not enabled on the cycle of that branch's own commit.
- R4: A committed call (kind 1) is itself seen at the current depth. Every later instruction runs one level deeper, so entries at the caller's level stay disabled while the callee runs.
- R5: A committed return (kind 2) lowers the depth by one, so that paused entries at the caller's level are enabled again for the instructions that follow.
- R6: A return committed at or above an active entry's home level retires that entry. It stays disabled at that level afterwards until its branch commits again.
- R7: A branch that commits again while it already has an entry reuses that entry, re-activates it and records the current depth. No other entry is claimed.
- R8: A branch that misses claims entries in rotating order starting at index 0, wrapping after the last index and replacing the earlier owner.
- R9: The query port reports a hit and the index of the entry that holds the queried PC, and reports a miss for PCs that have no entry.
- R10: The call depth saturates at its maximum value on further calls and stays at 0 on a return at depth 0. A return at depth 0 retires entries homed at level 0.
- R11: The enable vector is all zero in any cycle without a committed instruction.
- R12: A committed instruction enables every active entry at the current depth at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_valid | input | 1 | An instruction commits this cycle |
| commit_kind | input | 2 | 0 plain, 1 call, 2 return, 3 branch |
| commit_pc | input | PC_W | PC of the committing instruction |
| query_pc | input | PC_W | Branch PC to look up |
| query_hit | output | 1 | Queried PC has an entry |
| query_idx | output | clog2(ENTRIES) | Index of the matching entry |
| train_en | output | ENTRIES | Per-entry training enable for the current commit |
| cur_depth | output | DEPTH_W | Current call depth |

## Verification
The hardest states to reach are an entry paused under a deeper callee whose own level is later unwound, and the saturation edges of the depth counter. A paused entry must come back after the callee returns, while a retired one must stay dark when execution later revisits the same level. The stimulus builds nested call and return chains around branch commits. It pushes the depth past its ceiling and below zero, and it re-commits a branch at a different level. A reference model of the table predicts the enable vector for every commit.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

    typedef enum logic [1:0] {
        CK_PLAIN  = 2'd0,
        CK_CALL   = 2'd1,
        CK_RET    = 2'd2,
        CK_BRANCH = 2'd3
    } commit_kind_e;

    // Next call depth after a committed instruction, saturating at both ends.
    function automatic int unsigned step_depth(int unsigned cur,
                                               commit_kind_e kind,
                                               int unsigned ceiling);
        int unsigned nxt;
        nxt = cur;
        if (kind == CK_CALL && cur < ceiling) nxt = cur + 1;
        if (kind == CK_RET && cur > 0)        nxt = cur - 1;
        return nxt;
    endfunction

endpackage

// File: rtl/rcv_depth_ctr.sv
module rcv_depth_ctr
    import rcv_pkg::*;
#(
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_valid,
    input  commit_kind_e       kind,
    output logic [DEPTH_W-1:0] depth
);
    localparam int unsigned CEILING = (1 << DEPTH_W) - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else if (step_valid) begin
            depth <= DEPTH_W'(step_depth(32'(depth), kind, CEILING));
        end
    end
endmodule

// File: rtl/rcv_pc_match.sv
module rcv_pc_match #(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 32,
    parameter int IDX_W   = 3
) (
    input  logic [PC_W-1:0]         key,
    input  logic [ENTRIES-1:0]      valid,
    input  logic [ENTRIES*PC_W-1:0] tags,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g*PC_W +: PC_W] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/rcv_rr_alloc.sv
module rcv_rr_alloc #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rcv_gate_table.sv
module rcv_gate_table
    import rcv_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 32,
    parameter int DEPTH_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       commit_valid,
    input  logic [1:0]                 commit_kind,
    input  logic [PC_W-1:0]            commit_pc,
    input  logic [PC_W-1:0]            query_pc,
    output logic                       query_hit,
    output logic [$clog2(ENTRIES)-1:0] query_idx,
    output logic [ENTRIES-1:0]         train_en,
    output logic [DEPTH_W-1:0]         cur_depth
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic               valid;
        logic               active;
        logic [DEPTH_W-1:0] lvl;
        logic [PC_W-1:0]    pc;
    } ent_t;

    ent_t ent_q [ENTRIES];

    commit_kind_e kind;
    logic         is_br;
    logic         is_ret;

    assign kind   = commit_kind_e'(commit_kind);
    assign is_br  = commit_valid && (kind == CK_BRANCH);
    assign is_ret = commit_valid && (kind == CK_RET);

    logic [ENTRIES-1:0]         valid_vec;
    logic [ENTRIES-1:0]         active_vec;
    logic [ENTRIES*PC_W-1:0]    tag_flat;
    logic [ENTRIES*DEPTH_W-1:0] lvl_flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign valid_vec[g]                  = ent_q[g].valid;
        assign active_vec[g]                 = ent_q[g].active;
        assign tag_flat[g*PC_W +: PC_W]      = ent_q[g].pc;
        assign lvl_flat[g*DEPTH_W +: DEPTH_W] = ent_q[g].lvl;
    end

    rcv_depth_ctr #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk        (clk),
        .rst        (rst),
        .step_valid (commit_valid),
        .kind       (kind),
        .depth      (cur_depth)
    );

    logic             c_hit;
    logic [IDX_W-1:0] c_idx;

    rcv_pc_match #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_commit_match (
        .key   (commit_pc),
        .valid (valid_vec),
        .tags  (tag_flat),
        .hit   (c_hit),
        .idx   (c_idx)
    );

    rcv_pc_match #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_query_match (
        .key   (query_pc),
        .valid (valid_vec),
        .tags  (tag_flat),
        .hit   (query_hit),
        .idx   (query_idx)
    );

    logic [IDX_W-1:0] rr_ptr;

    rcv_rr_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
        .clk     (clk),
        .rst     (rst),
        .advance (is_br && !c_hit),
        .ptr     (rr_ptr)
    );

    // Entry claimed by a branch commit this cycle (existing owner or next victim).
    logic [IDX_W-1:0]   tgt_idx;
    logic [ENTRIES-1:0] tgt;

    assign tgt_idx = c_hit ? c_idx : rr_ptr;

    always_comb begin
        tgt = '0;
        if (is_br) tgt[tgt_idx] = 1'b1;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign train_en[g] = commit_valid && ent_q[g].active &&
                             (ent_q[g].lvl == cur_depth) && !tgt[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (tgt[g]) begin
                ent_q[g].valid  <= 1'b1;
                ent_q[g].active <= 1'b1;
                ent_q[g].lvl    <= cur_depth;
                ent_q[g].pc     <= commit_pc;
            end else if (is_ret && ent_q[g].active && (ent_q[g].lvl >= cur_depth)) begin
                ent_q[g].active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rcv_gate_table_chk.sv
module rcv_gate_table_chk #(
    parameter int ENTRIES = 8,
    parameter int DEPTH_W = 4,
    parameter int IDX_W   = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       commit_valid,
    input logic [1:0]                 commit_kind,
    input logic [ENTRIES-1:0]         train_en,
    input logic [DEPTH_W-1:0]         cur_depth,
    input logic [ENTRIES-1:0]         active_vec,
    input logic [ENTRIES-1:0]         valid_vec,
    input logic [ENTRIES*DEPTH_W-1:0] lvl_flat,
    input logic                       query_hit,
    input logic [IDX_W-1:0]           query_idx
);
    localparam logic [DEPTH_W-1:0] CEIL = {DEPTH_W{1'b1}};

    logic deeper_active;
    always_comb begin
        deeper_active = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (active_vec[i] && (lvl_flat[i*DEPTH_W +: DEPTH_W] > cur_depth))
                deeper_active = 1'b1;
        end
    end

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !commit_valid |-> (train_en == '0));

    // R3
    en_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
        (train_en & ~active_vec) == '0);

    // R4
    call_step_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_kind == 2'd1 && cur_depth != CEIL)
        |=> (cur_depth == DEPTH_W'($past(cur_depth) + 1'b1)));

    // R5
    ret_step_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_kind == 2'd2 && cur_depth != '0)
        |=> (cur_depth == DEPTH_W'($past(cur_depth) - 1'b1)));

    // R6
    no_deeper_active_chk: assert property (@(posedge clk) disable iff (rst)
        !deeper_active);

    // R9
    query_valid_chk: assert property (@(posedge clk) disable iff (rst)
        query_hit |-> valid_vec[query_idx]);

    // R10
    top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_kind == 2'd1 && cur_depth == CEIL) |=> (cur_depth == CEIL));
endmodule

bind rcv_gate_table rcv_gate_table_chk #(
    .ENTRIES (ENTRIES),
    .DEPTH_W (DEPTH_W),
    .IDX_W   ($clog2(ENTRIES))
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .commit_valid (commit_valid),
    .commit_kind  (commit_kind),
    .train_en     (train_en),
    .cur_depth    (cur_depth),
    .active_vec   (active_vec),
    .valid_vec    (valid_vec),
    .lvl_flat     (lvl_flat),
    .query_hit    (query_hit),
    .query_idx    (query_idx)
);

// File: tb/rcv_gate_table_bench.sv
`timescale 1ns/1ps
module rcv_gate_table_bench;
    localparam int ENT   = 8;
    localparam int PW    = 32;
    localparam int DW    = 4;
    localparam int CEIL  = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          commit_valid = 1'b0;
    logic [1:0]    commit_kind = 2'd0;
    logic [PW-1:0] commit_pc = '0;
    logic [PW-1:0] query_pc = '0;
    logic          query_hit;
    logic [2:0]    query_idx;
    logic [ENT-1:0] train_en;
    logic [DW-1:0]  cur_depth;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rcv_gate_table #(.ENTRIES(ENT), .PC_W(PW), .DEPTH_W(DW)) u_rcv_gate_table (
        .clk(clk), .rst(rst), .commit_valid(commit_valid), .commit_kind(commit_kind),
        .commit_pc(commit_pc), .query_pc(query_pc), .query_hit(query_hit),
        .query_idx(query_idx), .train_en(train_en), .cur_depth(cur_depth)
    );

    // Reference model of the table.
    bit          m_valid [ENT];
    bit          m_act   [ENT];
    int          m_lvl   [ENT];
    int unsigned m_pc    [ENT];
    int          m_rr = 0;
    int          m_depth = 0;

    logic [ENT-1:0] exp_q [$];
    string          tag_q [$];

    function automatic int m_find(int unsigned pc);
        for (int i = 0; i < ENT; i++) if (m_valid[i] && m_pc[i] == pc) return i;
        return -1;
    endfunction

    function automatic logic [ENT-1:0] m_en(int kind, int unsigned pc);
        logic [ENT-1:0] e;
        int h;
        int tgt;
        e = '0;
        h = m_find(pc);
        tgt = (kind == 3) ? ((h >= 0) ? h : m_rr) : -1;
        for (int i = 0; i < ENT; i++)
            if (m_act[i] && m_lvl[i] == m_depth && i != tgt) e[i] = 1'b1;
        return e;
    endfunction

    task automatic m_step(int kind, int unsigned pc);
        int h;
        int tgt;
        if (kind == 3) begin
            h = m_find(pc);
            tgt = (h >= 0) ? h : m_rr;
            if (h < 0) m_rr = (m_rr + 1) % ENT;
            m_valid[tgt] = 1; m_act[tgt] = 1; m_lvl[tgt] = m_depth; m_pc[tgt] = pc;
        end
        if (kind == 2)
            for (int i = 0; i < ENT; i++) if (m_act[i] && m_lvl[i] >= m_depth) m_act[i] = 0;
        if (kind == 1 && m_depth < CEIL) m_depth++;
        if (kind == 2 && m_depth > 0) m_depth--;
    endtask

    // Driver: one commit per cycle, expected enable pushed to the scoreboard.
    task automatic commit(int kind, int unsigned pc, string req);
        @(posedge clk); #1;
        commit_valid = 1'b1;
        commit_kind  = 2'(kind);
        commit_pc    = pc;
        exp_q.push_back(m_en(kind, pc));
        tag_q.push_back(req);
        m_step(kind, pc);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        commit_valid = 1'b0;
    endtask

    // Monitor: compares each commit's enable vector between edges.
    always @(negedge clk) begin
        if (!rst && commit_valid && exp_q.size() > 0) begin
            logic [ENT-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (train_en !== e) begin
                fails++;
                $display("FAIL %s: train_en actual %b expected %b", t, train_en, e);
            end
        end
    end

    task automatic check_query(int unsigned pc, bit hit, int idx, string req);
        query_pc = pc;
        #1;
        checks++;
        if (query_hit !== hit || (hit && query_idx !== 3'(idx))) begin
            fails++;
            $display("FAIL %s: query %h actual hit=%0b idx=%0d expected hit=%0b idx=%0d",
                     req, pc, query_hit, query_idx, hit, idx);
        end
    endtask

    task automatic check_depth(int d, string req);
        checks++;
        if (cur_depth !== DW'(d)) begin
            fails++;
            $display("FAIL %s: depth actual %0d expected %0d", req, cur_depth, d);
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check_depth(0, "R1");
        checks++;
        if (train_en !== '0) begin
            fails++;
            $display("FAIL R1: train_en actual %b expected 0", train_en);
        end
        check_query(32'h100, 0, 0, "R1");

        commit(0, 32'h10, "R2");              // no entries yet
        commit(3, 32'h100, "R3");             // A claims 0, silent on own commit
        commit(0, 32'h14, "R3");
        commit(3, 32'h200, "R12");            // B claims 1, A trains
        commit(0, 32'h18, "R12");             // both train
        commit(1, 32'h1c, "R4");              // call trains at caller level
        commit(0, 32'h800, "R4");             // callee: caller entries paused
        commit(3, 32'h300, "R4");             // C at depth 1
        commit(0, 32'h804, "R4");
        commit(2, 32'h808, "R6");             // return retires C
        commit(0, 32'h20, "R5");              // A, B resume
        commit(1, 32'h24, "R6");
        commit(0, 32'h800, "R6");             // C stays dark at level 1
        commit(2, 32'h808, "R6");
        commit(0, 32'h28, "R5");
        idle();
        check_depth(0, "R5");
        check_query(32'h100, 1, 0, "R9");
        check_query(32'h200, 1, 1, "R9");
        check_query(32'h300, 1, 2, "R8");

        commit(1, 32'h2c, "R7");
        commit(3, 32'h100, "R7");             // A re-homed at level 1
        commit(0, 32'h900, "R7");
        commit(2, 32'h904, "R7");             // retires A at level 1
        commit(0, 32'h30, "R7");
        idle();
        check_query(32'h100, 1, 0, "R7");

        for (int k = 4; k <= 9; k++) commit(3, 32'(k * 32'h100), "R8");
        commit(0, 32'h34, "R12");
        idle();
        check_query(32'h900, 1, 0, "R8");     // wrapped onto index 0
        check_query(32'h100, 0, 0, "R8");     // A replaced
        check_query(32'h800, 1, 7, "R8");
        check_query(32'h5555, 0, 0, "R9");

        for (int k = 0; k < 17; k++) commit(1, 32'h40, "R10");
        idle();
        check_depth(CEIL, "R10");
        commit(3, 32'hA00, "R10");            // J at top level, claims 1
        commit(1, 32'h44, "R10");             // saturated call
        commit(0, 32'h48, "R10");             // J still at same level
        for (int k = 0; k < 17; k++) commit(2, 32'h50, "R10");
        idle();
        check_depth(0, "R10");
        check_query(32'hA00, 1, 1, "R9");
        commit(3, 32'hB00, "R10");            // K at level 0, claims 2
        commit(0, 32'h54, "R10");
        commit(2, 32'h58, "R10");             // return at 0 retires K
        commit(0, 32'h5c, "R10");
        idle();
        check_depth(0, "R10");

        // R11 no commit, nothing enabled
        commit(3, 32'hC00, "R11");
        idle();
        #1;
        checks++;
        if (train_en !== '0) begin
            fails++;
            $display("FAIL R11: train_en actual %b expected 0", train_en);
        end

        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule